// File: doc/BRIEF.md
# SPI Burst Transfer Sequencer

This block is the transfer engine of an SPI master. It takes 32-bit words from a transmit FIFO and sends a programmed number of bits, one byte at a time, through a byte-wide exchange handshake with the serial shifter. The bits of a burst can span several FIFO words. Each word goes out lowest byte first. The bytes that come back are packed into a receive word, which is pushed into a receive FIFO. If the receive FIFO is full, the word is dropped and an overflow flag is raised.

Software-side logic outside the block owns the control fields and passes them in as levels. These fields are the burst length, the selected channel, the per-channel master bits, the per-channel slave-select control bits and the start-on-write bit. A control write strobe carries the value written to the exchange bit. The engine begins work in one of two ways. With start-on-write set, it starts when a word is written or when that bit is newly set. With start-on-write clear, it starts when the exchange bit is newly written to one. Normally the engine stops at the end of a burst. When multi-burst mode applies, it keeps running across burst boundaries until the transmit FIFO is empty.

Top module: `spi_burst_seq`

## Requirements
- R1: After reset, busy, xch, tc_flag, ovf_flag, tx_pop, rx_push and sh_req are all 0.
- R2: The burst length in bits is cfg_blen + 1. The engine loads it into a signed down-counter whenever the counter is zero or negative at the start of a word. The counter keeps its value between runs and drops by 8 for each byte exchanged.
- R3: Each popped word sends ceil(min(remaining bits, 32) / 8) bytes. Byte 0 (bits 7:0) goes first, then the higher bytes in order.
- R4: The first received byte lands in rx_data bits 7:0 and the next bytes fill the higher lanes. Lanes with no byte received read 0.
- R5: When a word completes, it is pushed with rx_push if rx_full is 0. Otherwise the word is dropped and ovf_flag is set.
- R6: Outside multi-burst mode, the end of a burst (counter zero or negative) does three things: it clears xch, it sets tc_flag, and it stops the engine even when words remain in the transmit FIFO.
- R7: Multi-burst mode applies when the selected channel is a master, cfg_auto is 0 and cfg_ssctl[cfg_chan] is 1. In this mode xch is set at every burst start and cleared at every burst end, and the engine continues with the next word.
- R8: tc_flag is set whenever the engine finds the transmit FIFO empty at a word start, and the engine then stops. tc_flag and ovf_flag hold until a tc_clr or ovf_clr pulse. A set in the same cycle wins over a clear.
- R9: With cfg_auto = 1 on a master channel, a tx_wr pulse starts the engine. So does a ctl_wr that raises cfg_auto from 0 to 1 while tx_empty is 0.
- R10: With cfg_auto = 0, a ctl_wr that raises xch from 0 to 1 starts the engine. This applies only when cfg_master[cfg_chan] is 1. Otherwise nothing starts.
- R11: sh_req stays high with a stable sh_tx_byte until sh_done. It then stays low for at least one cycle before the next byte.
- R12: busy is high from the cycle after a start until the engine stops. Start requests that arrive while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_blen | input | BLEN_W | Burst length minus one, in bits |
| cfg_chan | input | CH_W | Selected channel |
| cfg_master | input | NCH | Per-channel master-mode bits |
| cfg_ssctl | input | NCH | Per-channel slave-select control bits |
| cfg_auto | input | 1 | Start-on-write bit |
| ctl_wr | input | 1 | Control write strobe |
| ctl_xch | input | 1 | Exchange bit value carried by ctl_wr |
| tx_wr | input | 1 | A word was written to the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | DATA_W | Head word of the transmit FIFO |
| tx_pop | output | 1 | Pop the transmit FIFO |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Push rx_data into the receive FIFO |
| rx_data | output | DATA_W | Assembled receive word |
| sh_req | output | 1 | Byte exchange request to the shifter |
| sh_tx_byte | output | 8 | Byte to send |
| sh_done | input | 1 | Shifter finished the byte |
| sh_rx_byte | input | 8 | Byte received, valid with sh_done |
| tc_clr | input | 1 | Clear tc_flag |
| ovf_clr | input | 1 | Clear ovf_flag |
| xch | output | 1 | Exchange bit |
| tc_flag | output | 1 | Transfer complete |
| ovf_flag | output | 1 | Receive overflow |
| busy | output | 1 | Engine running |

## Verification
The receive-overflow discard and the end-of-burst stop land in the same clock cycle when a one-word burst completes against a full receive FIFO. The bench provokes this by holding rx_full high through a 32-bit burst. It then checks three things: no word was pushed, ovf_flag and tc_flag both rose together, and busy fell. Afterwards it clears ovf alone to confirm that the two flags are held separately.

// File: rtl/spi_seq_pkg.sv
`timescale 1ns/1ps
package spi_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WORD,
    S_REQ,
    S_ADV,
    S_FIN
  } seq_state_e;
endpackage

// File: rtl/spi_seq_start.sv
`timescale 1ns/1ps
module spi_seq_start #(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_W-1:0] cfg_chan,
  input  logic [NCH-1:0]  cfg_master,
  input  logic [NCH-1:0]  cfg_ssctl,
  input  logic            cfg_auto,
  input  logic            ctl_wr,
  input  logic            ctl_xch,
  input  logic            tx_wr,
  input  logic            tx_empty,
  input  logic            xch_cur,
  input  logic            busy,
  output logic            start,
  output logic            multi
);
  logic auto_q, auto_d;
  logic is_master, auto_rise, xch_rise;

  // Remember the last written start-on-write value to spot a new set.
  always_comb begin
    auto_d = auto_q;
    if (ctl_wr) auto_d = cfg_auto;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) auto_q <= 1'b0;
    else        auto_q <= auto_d;
  end

  always_comb begin
    is_master = cfg_master[cfg_chan];
    auto_rise = ctl_wr & cfg_auto & ~auto_q;
    xch_rise  = ctl_wr & ctl_xch & ~xch_cur;
    multi     = is_master & ~cfg_auto & cfg_ssctl[cfg_chan];
    start     = ~busy & is_master &
                ((cfg_auto & tx_wr) | (auto_rise & ~tx_empty) |
                 (~cfg_auto & xch_rise));
  end
endmodule

// File: rtl/spi_seq_core.sv
`timescale 1ns/1ps
module spi_seq_core
  import spi_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BLEN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              multi,
  input  logic              ctl_wr,
  input  logic              ctl_xch,
  input  logic [BLEN_W-1:0] cfg_blen,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              sh_req,
  output logic [7:0]        sh_tx_byte,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx_byte,
  input  logic              tc_clr,
  input  logic              ovf_clr,
  output logic              xch,
  output logic              tc_flag,
  output logic              ovf_flag,
  output logic              busy
);
  localparam int NBYTE = DATA_W / 8;
  localparam int BI_W  = $clog2(NBYTE + 1);
  localparam int CNT_W = BLEN_W + 2;

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, load_val, eff_cnt;
  logic [BI_W-1:0]   bidx_q, bidx_d, nbyte_q, nbyte_d, word_bytes;
  logic [DATA_W-1:0] txsh_q, txsh_d, rxw_q, rxw_d;
  logic              xch_q, xch_d, tc_q, tc_d, ovf_q, ovf_d;
  logic              cnt_nonpos, dp_en;

  always_comb begin
    load_val   = {2'b00, cfg_blen} + CNT_W'(1);
    cnt_nonpos = cnt_q[CNT_W-1] | (cnt_q == '0);
    eff_cnt    = cnt_nonpos ? load_val : cnt_q;
    word_bytes = (eff_cnt >= CNT_W'(DATA_W)) ? BI_W'(NBYTE)
                                             : BI_W'((eff_cnt + CNT_W'(7)) >> 3);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bidx_d  = bidx_q;
    nbyte_d = nbyte_q;
    txsh_d  = txsh_q;
    rxw_d   = rxw_q;
    xch_d   = ctl_wr ? ctl_xch : xch_q;
    tc_d    = tc_q & ~tc_clr;
    ovf_d   = ovf_q & ~ovf_clr;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    sh_req  = 1'b0;
    dp_en   = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) state_d = S_WORD;
      S_WORD: begin
        if (tx_empty) begin
          tc_d    = 1'b1;
          state_d = S_IDLE;
        end else begin
          if (cnt_nonpos) begin
            cnt_d = load_val;
            if (multi) xch_d = 1'b1;
          end
          tx_pop  = 1'b1;
          dp_en   = 1'b1;
          txsh_d  = tx_data;
          rxw_d   = '0;
          bidx_d  = '0;
          nbyte_d = word_bytes;
          state_d = S_REQ;
        end
      end
      S_REQ: begin
        sh_req = 1'b1;
        if (sh_done) begin
          dp_en = 1'b1;
          for (int b = 0; b < NBYTE; b++)
            if (bidx_q == BI_W'(b)) rxw_d[b*8 +: 8] = sh_rx_byte;
          txsh_d  = txsh_q >> 8;
          cnt_d   = cnt_q - CNT_W'(8);
          bidx_d  = bidx_q + BI_W'(1);
          state_d = S_ADV;
        end
      end
      S_ADV: state_d = (bidx_q == nbyte_q) ? S_FIN : S_REQ;
      S_FIN: begin
        if (rx_full) ovf_d = 1'b1;
        else         rx_push = 1'b1;
        state_d = S_WORD;
        if (cnt_nonpos) begin
          xch_d = 1'b0;
          if (!multi) begin
            tc_d    = 1'b1;
            state_d = S_IDLE;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      nbyte_q <= '0;
      xch_q   <= 1'b0;
      tc_q    <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bidx_q  <= bidx_d;
      nbyte_q <= nbyte_d;
      xch_q   <= xch_d;
      tc_q    <= tc_d;
      ovf_q   <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsh_q <= '0;
      rxw_q  <= '0;
    end else if (dp_en) begin
      txsh_q <= txsh_d;
      rxw_q  <= rxw_d;
    end
  end

  assign rx_data    = rxw_q;
  assign sh_tx_byte = txsh_q[7:0];
  assign xch        = xch_q;
  assign tc_flag    = tc_q;
  assign ovf_flag   = ovf_q;
  assign busy       = (state_q != S_IDLE);
endmodule

// File: rtl/spi_burst_seq.sv
`timescale 1ns/1ps
module spi_burst_seq #(
  parameter int DATA_W = 32,
  parameter int BLEN_W = 12,
  parameter int NCH    = 4,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLEN_W-1:0] cfg_blen,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [NCH-1:0]    cfg_master,
  input  logic [NCH-1:0]    cfg_ssctl,
  input  logic              cfg_auto,
  input  logic              ctl_wr,
  input  logic              ctl_xch,
  input  logic              tx_wr,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              sh_req,
  output logic [7:0]        sh_tx_byte,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx_byte,
  input  logic              tc_clr,
  input  logic              ovf_clr,
  output logic              xch,
  output logic              tc_flag,
  output logic              ovf_flag,
  output logic              busy
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n, start, multi;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  spi_seq_start #(.NCH(NCH), .CH_W(CH_W)) start_i (
    .clk(clk), .rst_n(rst_i_n), .cfg_chan(cfg_chan), .cfg_master(cfg_master),
    .cfg_ssctl(cfg_ssctl), .cfg_auto(cfg_auto), .ctl_wr(ctl_wr),
    .ctl_xch(ctl_xch), .tx_wr(tx_wr), .tx_empty(tx_empty), .xch_cur(xch),
    .busy(busy), .start(start), .multi(multi)
  );

  spi_seq_core #(.DATA_W(DATA_W), .BLEN_W(BLEN_W)) core_i (
    .clk(clk), .rst_n(rst_i_n), .start(start), .multi(multi),
    .ctl_wr(ctl_wr), .ctl_xch(ctl_xch), .cfg_blen(cfg_blen),
    .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
    .sh_req(sh_req), .sh_tx_byte(sh_tx_byte), .sh_done(sh_done),
    .sh_rx_byte(sh_rx_byte), .tc_clr(tc_clr), .ovf_clr(ovf_clr),
    .xch(xch), .tc_flag(tc_flag), .ovf_flag(ovf_flag), .busy(busy)
  );
endmodule

// File: rtl/spi_burst_seq_chk.sv
`timescale 1ns/1ps
module spi_burst_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       tx_pop,
  input logic       tx_empty,
  input logic       rx_push,
  input logic       rx_full,
  input logic       sh_req,
  input logic       sh_done,
  input logic [7:0] sh_tx_byte,
  input logic       tc_flag,
  input logic       ovf_flag
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_req && !sh_done) |=> (sh_req && $stable(sh_tx_byte)));
  // R11
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_req && sh_done) |=> !sh_req);
  // R5
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);
  // R5
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(rx_full));
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tx_pop && !rx_push && !sh_req));
  // R8
  stop_sets_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> tc_flag);
  // R3
  pop_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);
endmodule

bind spi_burst_seq spi_burst_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .tx_pop(tx_pop),
  .tx_empty(tx_empty), .rx_push(rx_push), .rx_full(rx_full),
  .sh_req(sh_req), .sh_done(sh_done), .sh_tx_byte(sh_tx_byte),
  .tc_flag(tc_flag), .ovf_flag(ovf_flag)
);

// File: tb/spi_burst_seq_tb_top.sv
`timescale 1ns/1ps
module spi_burst_seq_tb_top;
  localparam int DATA_W = 32;
  localparam int BLEN_W = 12;
  localparam int NCH    = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [BLEN_W-1:0] cfg_blen;
  logic [1:0]        cfg_chan;
  logic [NCH-1:0]    cfg_master, cfg_ssctl;
  logic              cfg_auto, ctl_wr, ctl_xch, tx_wr, tx_empty;
  logic [DATA_W-1:0] tx_data, rx_data;
  logic              tx_pop, rx_full, rx_push, sh_req, sh_done;
  logic [7:0]        sh_tx_byte, sh_rx_byte;
  logic              tc_clr, ovf_clr, xch, tc_flag, ovf_flag, busy;

  always #2.5 clk = ~clk;

  spi_burst_seq #(.DATA_W(DATA_W), .BLEN_W(BLEN_W), .NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_blen(cfg_blen), .cfg_chan(cfg_chan),
    .cfg_master(cfg_master), .cfg_ssctl(cfg_ssctl), .cfg_auto(cfg_auto),
    .ctl_wr(ctl_wr), .ctl_xch(ctl_xch), .tx_wr(tx_wr), .tx_empty(tx_empty),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push),
    .rx_data(rx_data), .sh_req(sh_req), .sh_tx_byte(sh_tx_byte),
    .sh_done(sh_done), .sh_rx_byte(sh_rx_byte), .tc_clr(tc_clr),
    .ovf_clr(ovf_clr), .xch(xch), .tc_flag(tc_flag), .ovf_flag(ovf_flag),
    .busy(busy)
  );

  int n_chk = 0, n_bad = 0, n_push = 0;
  bit finished = 1'b0;
  logic [DATA_W-1:0] txq[$];
  logic [DATA_W-1:0] mq[$];
  logic [7:0]        exp_tx[$];
  logic [DATA_W:0]   exp_rx[$];
  int                m_cnt = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void refresh_tx();
    tx_empty = (txq.size() == 0);
    tx_data  = (txq.size() == 0) ? '0 : txq[0];
  endfunction

  // Expected items from the requirements: counter rules, byte order, packing.
  task automatic model_run(input int blen, input bit mb, input bit xe);
    while (mq.size() != 0) begin
      logic [DATA_W-1:0] w, r;
      int n, nb;
      if (m_cnt <= 0) m_cnt = blen + 1;
      w  = mq.pop_front();
      n  = (m_cnt < 32) ? m_cnt : 32;
      nb = (n + 7) / 8;
      r  = '0;
      for (int b = 0; b < nb; b++) begin
        exp_tx.push_back(w[b*8 +: 8]);
        r[b*8 +: 8] = w[b*8 +: 8] ^ 8'h5A;
        m_cnt -= 8;
      end
      if (!rx_full) exp_rx.push_back({xe, r});
      if (m_cnt <= 0 && !mb) break;
    end
  endtask

  task automatic push_tx(input logic [DATA_W-1:0] w, input bit run,
                         input bit mb, input bit xe);
    @(negedge clk);
    txq.push_back(w);
    mq.push_back(w);
    refresh_tx();
    tx_wr = 1'b1;
    if (run) model_run(int'(cfg_blen), mb, xe);
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic ctl_write(input bit au, input bit xv, input bit run,
                           input bit mb);
    @(negedge clk);
    cfg_auto = au;
    ctl_xch  = xv;
    ctl_wr   = 1'b1;
    if (run) model_run(int'(cfg_blen), mb, xv);
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  // TX FIFO pop: applied just after the edge that captured the head word.
  initial forever begin
    @(negedge clk);
    if (tx_pop) begin
      @(posedge clk);
      #1;
      void'(txq.pop_front());
      refresh_tx();
    end
  end

  // Shifter model with varying latency; checks each byte sent.
  initial begin
    int lat = 0;
    sh_done    = 1'b0;
    sh_rx_byte = '0;
    forever begin
      @(negedge clk);
      if (sh_req) begin
        logic [7:0] b, e;
        b = sh_tx_byte;
        e = (exp_tx.size() != 0) ? exp_tx.pop_front() : 8'hxx;
        chk(b === e, "R3 byte order", {56'd0, b}, {56'd0, e});
        repeat (lat % 3) @(negedge clk);
        lat++;
        sh_rx_byte = b ^ 8'h5A;
        sh_done    = 1'b1;
        @(negedge clk);
        sh_done = 1'b0;
      end
    end
  end

  // Scoreboard monitor on receive pushes (R4 packing, R7 xch during burst).
  initial forever begin
    @(negedge clk);
    if (rst_n && rx_push) begin
      logic [DATA_W:0] e;
      n_push++;
      e = (exp_rx.size() != 0) ? exp_rx.pop_front() : {1'b1, {DATA_W{1'bx}}};
      chk({xch, rx_data} === e, "R4 rx word/R7 xch", {31'd0, xch, rx_data},
          {31'd0, e});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int p0;
    rst_n = 1'b0; cfg_blen = '0; cfg_chan = 2'd1; cfg_master = 4'b0010;
    cfg_ssctl = '0; cfg_auto = 1'b0; ctl_wr = 1'b0; ctl_xch = 1'b0;
    tx_wr = 1'b0; rx_full = 1'b0; tc_clr = 1'b0; ovf_clr = 1'b0;
    refresh_tx();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, xch, tc_flag, ovf_flag, tx_pop, rx_push, sh_req} == 7'd0,
        "R1 reset", {57'd0, busy, xch, tc_flag, ovf_flag, tx_pop, rx_push, sh_req}, 0);

    // R9 start-on-write: setting the mode with empty TX starts nothing.
    cfg_blen = 12'd31;
    ctl_write(1'b1, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(!busy, "R9 no start when empty", {63'd0, busy}, 0);
    push_tx(32'h4433_2211, 1'b1, 1'b0, 1'b0);
    wait_idle();
    chk(tc_flag && txq.size() == 0, "R8 tc on empty", {63'd0, tc_flag}, 1);

    // R2/R4 16-bit burst: two bytes, upper lanes zero.
    cfg_blen = 12'd15;
    push_tx(32'hAABB_CCDD, 1'b1, 1'b0, 1'b0);
    wait_idle();
    @(negedge clk); tc_clr = 1'b1; @(negedge clk); tc_clr = 1'b0;
    @(negedge clk);
    chk(!tc_flag, "R8 tc clear", {63'd0, tc_flag}, 0);

    // R10/R6/R2: exchange start, 48-bit burst across words, stop with one left.
    cfg_blen = 12'd47;
    ctl_write(1'b0, 1'b0, 1'b0, 1'b0);
    push_tx(32'h0403_0201, 1'b0, 1'b0, 1'b0);
    push_tx(32'h0807_0605, 1'b0, 1'b0, 1'b0);
    push_tx(32'h0C0B_0A09, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(!busy, "R10 no start on write with auto clear", {63'd0, busy}, 0);
    ctl_write(1'b0, 1'b1, 1'b1, 1'b0);
    chk(busy, "R12 busy after start", {63'd0, busy}, 1);
    wait_idle();
    chk(txq.size() == 1, "R6 stop with words left", txq.size(), 1);
    chk(!xch && tc_flag, "R6 xch cleared tc set", {62'd0, xch, tc_flag}, 1);

    // R3/R2: 12-bit burst rounds up to two bytes.
    cfg_blen = 12'd11;
    ctl_write(1'b0, 1'b0, 1'b0, 1'b0);
    ctl_write(1'b0, 1'b1, 1'b1, 1'b0);
    wait_idle();
    chk(txq.size() == 0, "R3 partial word drained", txq.size(), 0);

    // R7 multi-burst: three 16-bit bursts back to back.
    cfg_blen = 12'd15; cfg_ssctl = 4'b0010;
    ctl_write(1'b0, 1'b0, 1'b0, 1'b0);
    push_tx(32'h1111_1234, 1'b0, 1'b0, 1'b0);
    push_tx(32'h2222_5678, 1'b0, 1'b0, 1'b0);
    push_tx(32'h3333_9ABC, 1'b0, 1'b0, 1'b0);
    ctl_write(1'b0, 1'b1, 1'b1, 1'b1);
    wait_idle();
    chk(txq.size() == 0 && !xch, "R7 continue until empty",
        {31'd0, xch, txq.size()}, 0);

    // R10 non-master channel never starts.
    cfg_master = 4'b0001; cfg_ssctl = '0;
    push_tx(32'hDEAD_0F0F, 1'b0, 1'b0, 1'b0);
    ctl_write(1'b0, 1'b0, 1'b0, 1'b0);
    ctl_write(1'b0, 1'b1, 1'b0, 1'b0);
    repeat (8) @(negedge clk);
    chk(!busy && txq.size() == 1, "R10 non-master idle",
        {31'd0, busy, txq.size()}, 1);

    // R9 newly set start-on-write with TX non-empty starts.
    cfg_master = 4'b0010; cfg_blen = 12'd31;
    ctl_write(1'b0, 1'b0, 1'b0, 1'b0);
    ctl_write(1'b1, 1'b0, 1'b1, 1'b0);
    wait_idle();
    chk(txq.size() == 0, "R9 start on mode set", txq.size(), 0);

    // R5 overflow coinciding with burst end.
    @(negedge clk); tc_clr = 1'b1; @(negedge clk); tc_clr = 1'b0;
    rx_full = 1'b1;
    p0 = n_push;
    push_tx(32'h5566_7788, 1'b1, 1'b0, 1'b0);
    wait_idle();
    chk(n_push == p0, "R5 word discarded", n_push, p0);
    chk(ovf_flag && tc_flag, "R5 ovf with tc", {62'd0, ovf_flag, tc_flag}, 3);
    rx_full = 1'b0;
    @(negedge clk); ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    @(negedge clk);
    chk(!ovf_flag && tc_flag, "R8 ovf clear alone", {62'd0, ovf_flag, tc_flag}, 1);

    repeat (4) @(negedge clk);
    chk(exp_tx.size() == 0 && exp_rx.size() == 0, "R3 all expected seen",
        exp_tx.size() + exp_rx.size(), 0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule